// File: doc/BRIEF.md
# Per-Block Lock State Controller

This controller keeps the write-protection state of every erase block in a flash array. Each block has two state bits. The lock bit blocks program and erase while it is set. The lock-down bit is sticky: only a hardware reset clears it. While the write-protect input is low, the lock-down bit pins the block in the locked state. The program/erase sequencer gives the controller decoded one-cycle lock, unlock and lock-down strobes with a block index. It also gives a program-suspend flag and a low-supply inhibit flag.

The controller drives one protection flag per block, which the sequencer consults before it starts a program or erase. It also drives a 2-bit status readback for one selected block, which serves the signature-read path. When the write-protect input is high, a block in lock-down can be unlocked and relocked one block at a time. When the write-protect input goes low again, that block becomes locked at once, whatever changes were made to it.

Top module: `blk_lock_ctrl`

## Requirements
- R1: While reset is asserted, and directly after it is released, every block has lock=1 and lock-down=0. The readback shows 2'b01 and every protection flag is 1.
- R2: A lock strobe sets the lock bit (readback bit 0) of the indexed block, and an unlock strobe clears it. The change is visible from the cycle after the clock edge that samples the strobe. Other blocks do not change.
- R3: A lock-down strobe sets both the lock-down bit (readback bit 1) and the lock bit of the indexed block.
- R4: No strobe clears a lock-down bit. Only reset clears it.
- R5: While write-protect is low (wp_release=0), a block with lock-down set reads locked and is protected. Lock and unlock strobes do not change it.
- R6: While write-protect is high, lock and unlock strobes change the lock bit of a block in lock-down. Its lock-down bit stays set.
- R7: When write-protect goes low, a block in lock-down reads locked in the same cycle, without waiting for a clock edge. It stays locked after write-protect goes high again.
- R8: While supply_low is 1, every protection flag is 1. The readback bits are not affected.
- R9: While prog_suspend is 1, lock, unlock and lock-down strobes have no effect.
- R10: A strobe whose index is NUM_BLOCKS or greater has no effect. A readback index of NUM_BLOCKS or greater returns 2'b00.
- R11: The readback follows rd_idx combinationally.
- R12: If several strobes arrive in one cycle, lock-down takes precedence over lock, and lock takes precedence over unlock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low hardware reset |
| cmd_lock | input | 1 | Lock strobe for block cmd_idx |
| cmd_unlock | input | 1 | Unlock strobe for block cmd_idx |
| cmd_ldown | input | 1 | Lock-down strobe for block cmd_idx |
| cmd_idx | input | IDX_W | Target block of the strobes |
| wp_release | input | 1 | Write-protect level; 1 releases lock-down for commands |
| supply_low | input | 1 | Program supply below lockout; protects all blocks |
| prog_suspend | input | 1 | Program suspended; lock commands rejected |
| rd_idx | input | IDX_W | Block selected for readback |
| rd_status | output | 2 | {lock-down, effective lock} of block rd_idx |
| protected_o | output | NUM_BLOCKS | Per-block program/erase protection flag |

## Verification
The effect of a strobe appears one edge after the strobe is sampled. The bench therefore drives the strobes, advances one rising edge, and then compares the outputs 1 ns after that edge. Write-protect, supply-inhibit and readback-index changes act combinationally, so the bench checks them within the same cycle, a nanosecond after the input changes, before any edge. The reference model advances only on the rising edges the bench itself produces, so that the model and the design see the same sequence of edges.

// File: rtl/blk_lock_ctrl.sv
module blk_lock_ctrl #(
  parameter int NUM_BLOCKS = 39,
  localparam int IDX_W = (NUM_BLOCKS > 1) ? $clog2(NUM_BLOCKS) : 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cmd_lock,
  input  logic                  cmd_unlock,
  input  logic                  cmd_ldown,
  input  logic [IDX_W-1:0]      cmd_idx,
  input  logic                  wp_release,
  input  logic                  supply_low,
  input  logic                  prog_suspend,
  input  logic [IDX_W-1:0]      rd_idx,
  output logic [1:0]            rd_status,
  output logic [NUM_BLOCKS-1:0] protected_o
);

  logic [NUM_BLOCKS-1:0] lock_q, ldn_q, frozen, eff_lock, sel;
  logic cmd_ok, rd_ok;

  assign cmd_ok   = !prog_suspend && (int'(cmd_idx) < NUM_BLOCKS);
  assign frozen   = ldn_q & {NUM_BLOCKS{~wp_release}};
  assign eff_lock = lock_q | frozen;

  for (genvar i = 0; i < NUM_BLOCKS; i++) begin : g_blk
    assign sel[i] = cmd_ok && (cmd_idx == IDX_W'(i));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        lock_q[i] <= 1'b1;
        ldn_q[i]  <= 1'b0;
      end else if (sel[i] && cmd_ldown) begin
        lock_q[i] <= 1'b1;
        ldn_q[i]  <= 1'b1;
      end else if (frozen[i]) begin
        lock_q[i] <= 1'b1;
      end else if (sel[i] && cmd_lock) begin
        lock_q[i] <= 1'b1;
      end else if (sel[i] && cmd_unlock) begin
        lock_q[i] <= 1'b0;
      end
    end
  end

  assign protected_o = eff_lock | {NUM_BLOCKS{supply_low}};

  assign rd_ok     = int'(rd_idx) < NUM_BLOCKS;
  assign rd_status = rd_ok ? {ldn_q[rd_idx], eff_lock[rd_idx]} : 2'b00;

  a_r1_reset_state: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (lock_q == '1 && ldn_q == '0));

  a_r4_ldown_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((ldn_q & $past(ldn_q)) == $past(ldn_q)));

  a_r5_frozen_locked: assert property (@(posedge clk) disable iff (!rst_n)
    (!wp_release && rd_status[1]) |-> rd_status[0]);

  a_r8_supply_inhibit: assert property (@(posedge clk) disable iff (!rst_n)
    supply_low |-> (protected_o == '1));

  a_r9_suspend_reject: assert property (@(posedge clk) disable iff (!rst_n)
    (prog_suspend && wp_release) |=> ($stable(lock_q) && $stable(ldn_q)));

endmodule

// File: tb/blk_lock_ctrl_tb.sv
`timescale 1ns/1ps
module blk_lock_ctrl_tb;
  localparam int N = 39;
  localparam int W = 6;

  logic clk = 0, rst_n = 0;
  logic cmd_lock = 0, cmd_unlock = 0, cmd_ldown = 0;
  logic [W-1:0] cmd_idx = 0, rd_idx = 0;
  logic wp_release = 1, supply_low = 0, prog_suspend = 0;
  logic [1:0] rd_status;
  logic [N-1:0] protected_o;

  blk_lock_ctrl #(.NUM_BLOCKS(N)) u_dut (.*);

  always #5 clk = ~clk;

  int checks = 0, failures = 0;
  bit m_lock [N];
  bit m_ldn  [N];

  function automatic bit eff(int i);
    return m_lock[i] | (m_ldn[i] & ~wp_release);
  endfunction

  function automatic logic [1:0] exp_rd(int i);
    if (i >= N) return 2'b00;
    return {m_ldn[i], eff(i)};
  endfunction

  function automatic logic [N-1:0] exp_prot();
    logic [N-1:0] v;
    for (int i = 0; i < N; i++) v[i] = eff(i) | supply_low;
    return v;
  endfunction

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic model_edge();
    for (int i = 0; i < N; i++) begin
      bit hit, fz;
      hit = !prog_suspend && (int'(cmd_idx) < N) && (int'(cmd_idx) == i);
      fz = m_ldn[i] && !wp_release;
      if (hit && cmd_ldown) begin m_ldn[i] = 1; m_lock[i] = 1; end
      else if (fz) m_lock[i] = 1;
      else if (hit && cmd_lock) m_lock[i] = 1;
      else if (hit && cmd_unlock) m_lock[i] = 0;
    end
  endtask

  task automatic tick();
    model_edge();
    @(posedge clk);
    #1;
    cmd_lock = 0; cmd_unlock = 0; cmd_ldown = 0;
  endtask

  task automatic cmd(bit ld, bit lk, bit ul, int idx);
    cmd_ldown = ld; cmd_lock = lk; cmd_unlock = ul; cmd_idx = W'(idx);
    tick();
  endtask

  task automatic rd_chk(string req, int idx);
    rd_idx = W'(idx);
    #1;
    chk(req, 64'(rd_status), 64'(exp_rd(idx)));
  endtask

  task automatic reset_all();
    rst_n = 0;
    for (int i = 0; i < N; i++) begin m_lock[i] = 1; m_ldn[i] = 0; end
    repeat (2) @(posedge clk);
    #1;
    rst_n = 1;
  endtask

  initial begin
    #1_000_000;
    failures++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks + 1, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'h1A2B));
    reset_all();
    // R1
    rd_chk("R1", 0); rd_chk("R1", 38);
    chk("R1 prot", 64'(protected_o), 64'(exp_prot()));
    // R2
    cmd(0, 0, 1, 3); rd_chk("R2 unlock", 3); rd_chk("R2 neighbour", 4);
    chk("R2 prot", 64'(protected_o), 64'(exp_prot()));
    cmd(0, 1, 0, 3); rd_chk("R2 lock", 3);
    // R3
    cmd(0, 0, 1, 5); cmd(1, 0, 0, 5); rd_chk("R3 ldown", 5);
    // R5
    wp_release = 0; #1;
    cmd(0, 0, 1, 5); rd_chk("R5 unlock ignored", 5);
    chk("R5 prot", 64'(protected_o[5]), 64'(1));
    // R6
    wp_release = 1; #1;
    cmd(0, 0, 1, 5); rd_chk("R6 unlock", 5);
    chk("R6 value", 64'(rd_status), 64'(2'b10));
    // R7: same cycle
    wp_release = 0; #1;
    rd_chk("R7 immediate", 5);
    chk("R7 immediate val", 64'(rd_status), 64'(2'b11));
    tick();
    wp_release = 1; #1;
    rd_chk("R7 stays locked", 5);
    chk("R7 stays val", 64'(rd_status), 64'(2'b11));
    // R4
    cmd(0, 0, 1, 5); cmd(0, 1, 0, 5); cmd(0, 0, 1, 5);
    rd_chk("R4 ldown kept", 5);
    // R8
    supply_low = 1; #1;
    chk("R8 all prot", 64'(protected_o), 64'(exp_prot()));
    rd_chk("R8 readback", 3);
    supply_low = 0; #1;
    // R9
    prog_suspend = 1;
    cmd(0, 0, 1, 7); cmd(1, 0, 0, 8);
    rd_chk("R9 unlock rejected", 7); rd_chk("R9 ldown rejected", 8);
    prog_suspend = 0;
    // R10
    cmd(0, 0, 1, 45); cmd(1, 0, 0, 63);
    chk("R10 prot", 64'(protected_o), 64'(exp_prot()));
    rd_chk("R10 rd out of range", 50);
    // R11
    rd_chk("R11 sel a", 3); rd_chk("R11 sel b", 5); rd_chk("R11 sel c", 40);
    // R12
    cmd(0, 0, 1, 9); cmd(0, 1, 1, 9); rd_chk("R12 lock over unlock", 9);
    cmd(0, 0, 1, 10); cmd(1, 0, 1, 10); rd_chk("R12 ldown first", 10);
    // random
    for (int it = 0; it < 600; it++) begin
      int r;
      r = $urandom % 8;
      wp_release = ($urandom % 4) != 0;
      supply_low = ($urandom % 8) == 0;
      prog_suspend = ($urandom % 6) == 0;
      #1;
      cmd(r == 0, r == 1 || r == 4, r >= 2, $urandom % 48);
      chk("R2 R5 R6 R8 prot", 64'(protected_o), 64'(exp_prot()));
      for (int k = 0; k < 3; k++) rd_chk("R2 R4 R6 readback", $urandom % 44);
    end
    // R1 again
    wp_release = 1; supply_low = 0; prog_suspend = 0;
    reset_all();
    rd_chk("R1 ldown cleared", 5);
    chk("R1 prot after", 64'(protected_o), 64'(exp_prot()));
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule